// File: doc/BRIEF.md
# Byte memory DMA engine

This block moves a run of words between an on-chip memory holding 24-bit words and a byte-wide external memory port. Software loads an internal word address, a 14-bit external byte address, a control word and a word count. Loading a nonzero count starts the transfer at once. The external address sent to the pins is the 14-bit byte address with an 8-bit page taken from the upper byte of the control word placed above it, 22 bits in all.

Each internal word is split into one, two or three bytes, or built up from them. A 2-bit packing field selects how. Every external byte cycle has one setup cycle followed by a strobe whose length comes from a separate wait-state register. When the last word has moved, the count reads zero and a one-cycle interrupt pulse is raised. Software can either take the interrupt or poll the count register.

Top module: `byte_dma_engine`

## Requirements
- R1: A register write of a nonzero value to the count register (select 3) while the engine is idle makes `busy` high on the following cycle. Writing zero stores zero and starts nothing.
- R2: The count is in internal words. Every word moves 1 byte in packing modes 0 and 1, 2 bytes in mode 2 and 3 bytes in mode 3. The count register goes down by exactly one per finished word.
- R3: When the count reaches zero, `irq` is high for exactly one cycle. In that cycle `busy` is low and the count reads 0.
- R4: `ext_addr` is {control[15:8], external address[13:0]}. The external address (select 1) goes up by one per byte and wraps within 14 bits. The internal address (select 0) goes up by one per word. Both registers read back their advanced values.
- R5: The packing field is control[2:1]. Mode 0 uses word bits [7:0]. Mode 1 uses word bits [15:8]. Mode 2 moves bits [7:0] and then bits [15:8]. Mode 3 moves bits [23:16], then [15:8], then [7:0]. On external reads, all word bits outside the used lanes are written as zero.
- R6: Control bit 0 selects the direction. A 1 reads internal memory and drives external writes (`ext_wr`). A 0 drives external reads (`ext_rd`) and writes the assembled words into internal memory. `ext_rd` and `ext_wr` are never high together.
- R7: Each external byte cycle has one setup cycle with both strobes low, followed by a strobe lasting W+1 cycles. W is the wait field in bits [2:0] of register select 4, and it resets to 7.
- R8: While `busy` is high, writes to selects 0 to 3 are ignored and leave all four registers unchanged.
- R9: After reset, the engine is idle with `irq`, `ext_rd` and `ext_wr` low, and selects 0 to 3 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 internal addr, 1 external addr, 2 control, 3 count, 4 wait |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| im_addr | output | 14 | Internal memory word address |
| im_rd | output | 1 | Internal memory read; data is expected one cycle later |
| im_rdata | input | 24 | Internal memory read data |
| im_wr | output | 1 | Internal memory write |
| im_wdata | output | 24 | Internal memory write data |
| ext_addr | output | 22 | External byte address, page above low part |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_wdata | output | 8 | External write byte |
| ext_rdata | input | 8 | External read byte, sampled in the last strobe cycle |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with its default widths: 14-bit addresses, an 8-bit page, a 14-bit count and a 3-bit wait field. It confines traffic to small address windows that its own memory models cover. With these settings it can sweep every combination of the two directions, the four packing modes and all eight wait values, using counts from one to four words. This covers every strobe length and every byte-lane ordering. It also runs separate cases for wrap of the 14-bit external address, for a zero count, and for register writes made during a transfer.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

  localparam int WORD_W = 24;
  localparam int BYTE_W = 8;

  localparam logic [2:0] SEL_IADDR = 3'd0;
  localparam logic [2:0] SEL_EADDR = 3'd1;
  localparam logic [2:0] SEL_CTRL  = 3'd2;
  localparam logic [2:0] SEL_COUNT = 3'd3;
  localparam logic [2:0] SEL_WAIT  = 3'd4;

  typedef enum logic [1:0] {
    PK_LO8 = 2'd0,
    PK_HI8 = 2'd1,
    PK_16  = 2'd2,
    PK_24  = 2'd3
  } pack_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CAPT,
    ST_BSET,
    ST_BWAIT,
    ST_WEND
  } st_t;

  // index of the final byte of a word in the given packing
  function automatic logic [1:0] last_idx(pack_t m);
    case (m)
      PK_16:   return 2'd1;
      PK_24:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // byte driven on the external bus for lane i of word w
  function automatic logic [BYTE_W-1:0] pick_byte(logic [WORD_W-1:0] w, pack_t m,
                                                  logic [1:0] i);
    case (m)
      PK_LO8: return w[7:0];
      PK_HI8: return w[15:8];
      PK_16:  return i[0] ? w[15:8] : w[7:0];
      default: begin
        if (i == 2'd0)      return w[23:16];
        else if (i == 2'd1) return w[15:8];
        else                return w[7:0];
      end
    endcase
  endfunction

  // word after placing external byte b into lane i of accumulator acc
  function automatic logic [WORD_W-1:0] merge_byte(logic [WORD_W-1:0] acc,
                                                   logic [BYTE_W-1:0] b, pack_t m,
                                                   logic [1:0] i);
    case (m)
      PK_LO8: return {16'h0000, b};
      PK_HI8: return {8'h00, b, 8'h00};
      PK_16:  return i[0] ? {8'h00, b, acc[7:0]} : {16'h0000, b};
      default: begin
        if (i == 2'd0)      return {b, 16'h0000};
        else if (i == 2'd1) return {acc[23:16], b, 8'h00};
        else                return {acc[23:8], b};
      end
    endcase
  endfunction

endpackage

// File: rtl/bdma_strobe.sv
module bdma_strobe #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [WS_W-1:0] ws,
  output logic            active,
  output logic            last
);

  logic [WS_W-1:0] rem_q;
  logic            act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      act_q <= 1'b0;
    end else if (go) begin
      rem_q <= ws;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (rem_q == '0) act_q <= 1'b0;
      else             rem_q <= rem_q - 1'b1;
    end
  end

  assign active = act_q;
  assign last   = act_q && (rem_q == '0);

  // a new byte cycle may only be launched once the previous strobe ended
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !act_q);

  // a strobe always ends through its final cycle
  assert_strobe_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !last) |=> act_q);

endmodule

// File: rtl/bdma_lane.sv
module bdma_lane
  import bdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              take,
  input  pack_t             mode,
  input  logic [1:0]        idx,
  input  logic [WORD_W-1:0] in_word,
  input  logic [BYTE_W-1:0] ext_byte,
  output logic [WORD_W-1:0] word_q,
  output logic [BYTE_W-1:0] out_byte
);

  logic [WORD_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (load)  acc_q <= in_word;
    else if (take)  acc_q <= merge_byte(acc_q, ext_byte, mode, idx);
  end

  assign word_q   = acc_q;
  assign out_byte = pick_byte(acc_q, mode, idx);

  // a loaded word and a gathered byte never arrive in the same cycle
  assert_lane_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && take));

endmodule

// File: rtl/byte_dma_engine.sv
module byte_dma_engine
  import bdma_pkg::*;
#(
  parameter int IA_W   = 14,
  parameter int EA_W   = 14,
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 14,
  parameter int WS_W   = 3,
  parameter int REG_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr_en,
  input  logic [2:0]             reg_sel,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  output logic [IA_W-1:0]        im_addr,
  output logic                   im_rd,
  input  logic [WORD_W-1:0]      im_rdata,
  output logic                   im_wr,
  output logic [WORD_W-1:0]      im_wdata,
  output logic [PAGE_W+EA_W-1:0] ext_addr,
  output logic                   ext_rd,
  output logic                   ext_wr,
  output logic [BYTE_W-1:0]      ext_wdata,
  input  logic [BYTE_W-1:0]      ext_rdata,
  output logic                   busy,
  output logic                   irq
);

  localparam int PAGE_LSB = REG_W - PAGE_W;

  st_t               state;
  logic [IA_W-1:0]   ia_q;
  logic [EA_W-1:0]   ea_q;
  logic [REG_W-1:0]  ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WS_W-1:0]   ws_q;
  logic [1:0]        idx_q;
  logic              irq_q;

  pack_t             mode;
  logic              dir_wr;
  logic              idle;
  logic              start_evt;
  logic              byte_done;
  logic              word_done;
  logic              strb_go;
  logic              strb_active;
  logic              strb_last;
  logic              lane_clear;
  logic              lane_load;
  logic              lane_take;
  logic [WORD_W-1:0] lane_word;
  logic [BYTE_W-1:0] lane_byte;

  assign mode      = pack_t'(ctrl_q[2:1]);
  assign dir_wr    = ctrl_q[0];
  assign idle      = (state == ST_IDLE);
  assign start_evt = idle && reg_wr_en && (reg_sel == SEL_COUNT) &&
                     (reg_wdata[CNT_W-1:0] != '0);
  assign strb_go   = (state == ST_BSET);
  assign byte_done = (state == ST_BWAIT) && strb_last;
  assign word_done = (state == ST_WEND);

  assign lane_clear = start_evt || word_done;
  assign lane_load  = (state == ST_CAPT);
  assign lane_take  = byte_done && !dir_wr;

  bdma_strobe #(.WS_W(WS_W)) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (strb_go),
    .ws     (ws_q),
    .active (strb_active),
    .last   (strb_last)
  );

  bdma_lane u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (lane_clear),
    .load     (lane_load),
    .take     (lane_take),
    .mode     (mode),
    .idx      (idx_q),
    .in_word  (im_rdata),
    .ext_byte (ext_rdata),
    .word_q   (lane_word),
    .out_byte (lane_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ia_q   <= '0;
      ea_q   <= '0;
      ctrl_q <= '0;
      cnt_q  <= '0;
      ws_q   <= '1;
      idx_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (reg_wr_en && (reg_sel == SEL_WAIT)) ws_q <= reg_wdata[WS_W-1:0];
      case (state)
        ST_IDLE: begin
          if (reg_wr_en) begin
            case (reg_sel)
              SEL_IADDR: ia_q   <= reg_wdata[IA_W-1:0];
              SEL_EADDR: ea_q   <= reg_wdata[EA_W-1:0];
              SEL_CTRL:  ctrl_q <= reg_wdata;
              SEL_COUNT: begin
                cnt_q <= reg_wdata[CNT_W-1:0];
                idx_q <= '0;
                if (start_evt) state <= dir_wr ? ST_FETCH : ST_BSET;
              end
              default: ;
            endcase
          end
        end
        ST_FETCH: state <= ST_CAPT;
        ST_CAPT: begin
          idx_q <= '0;
          state <= ST_BSET;
        end
        ST_BSET: state <= ST_BWAIT;
        ST_BWAIT: begin
          if (strb_last) begin
            ea_q <= ea_q + 1'b1;
            if (idx_q == last_idx(mode)) begin
              state <= ST_WEND;
            end else begin
              idx_q <= idx_q + 1'b1;
              state <= ST_BSET;
            end
          end
        end
        ST_WEND: begin
          ia_q  <= ia_q + 1'b1;
          cnt_q <= cnt_q - 1'b1;
          idx_q <= '0;
          if (cnt_q == CNT_W'(1)) begin
            state <= ST_IDLE;
            irq_q <= 1'b1;
          end else begin
            state <= dir_wr ? ST_FETCH : ST_BSET;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_IADDR: reg_rdata = REG_W'(ia_q);
      SEL_EADDR: reg_rdata = REG_W'(ea_q);
      SEL_CTRL:  reg_rdata = ctrl_q;
      SEL_COUNT: reg_rdata = REG_W'(cnt_q);
      SEL_WAIT:  reg_rdata = REG_W'(ws_q);
      default:   reg_rdata = '0;
    endcase
  end

  assign im_addr   = ia_q;
  assign im_rd     = (state == ST_FETCH);
  assign im_wr     = word_done && !dir_wr;
  assign im_wdata  = lane_word;
  assign ext_addr  = {ctrl_q[PAGE_LSB +: PAGE_W], ea_q};
  assign ext_rd    = strb_active && !dir_wr;
  assign ext_wr    = strb_active && dir_wr;
  assign ext_wdata = lane_byte;
  assign busy      = !idle;
  assign irq       = irq_q;

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));

  assert_word_bytes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (idx_q == last_idx(mode)));

  assert_irq_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt_q == '0 && !busy));

  assert_ea_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (ea_q == $past(ea_q) + 1'b1));

  assert_one_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd && ext_wr));

  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr_en && reg_sel == SEL_CTRL) |=> $stable(ctrl_q));

endmodule

// File: tb/test_byte_dma_engine.sv
module test_byte_dma_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [13:0] im_addr;
  logic        im_rd;
  logic [23:0] im_rdata = 24'h0;
  logic        im_wr;
  logic [23:0] im_wdata;
  logic [21:0] ext_addr;
  logic        ext_rd, ext_wr;
  logic [7:0]  ext_wdata;
  logic [7:0]  ext_rdata;
  logic        busy, irq;

  always #10 clk = ~clk;

  byte_dma_engine i_byte_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .im_addr(im_addr),
    .im_rd(im_rd), .im_rdata(im_rdata), .im_wr(im_wr), .im_wdata(im_wdata),
    .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .busy(busy), .irq(irq)
  );

  logic [23:0] imem [0:63];
  logic [7:0]  xmem [0:255];

  always @(posedge clk) begin
    if (im_wr) imem[im_addr[5:0]] <= im_wdata;
    if (im_rd) im_rdata <= imem[im_addr[5:0]];
    if (ext_wr) xmem[ext_addr[7:0]] <= ext_wdata;
  end
  assign ext_rdata = xmem[ext_addr[7:0]];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int run_len = 0, n_strobes = 0, bad_width = 0, bad_page = 0, bad_dir = 0, irq_cnt = 0;
  int exp_ws = 7;
  logic [7:0] exp_page = 8'h00;
  bit exp_dir_wr = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (ext_rd || ext_wr) begin
        run_len++;
        if (ext_addr[21:14] != exp_page) bad_page++;
        if (ext_wr != exp_dir_wr) bad_dir++;
      end else if (run_len > 0) begin
        if (run_len != exp_ws + 1) bad_width++;
        n_strobes++;
        run_len = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [15:0] v);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  function automatic logic [23:0] pat_i(int i, int seed);
    return 24'((i * 32'h10305 + seed * 32'h2B1 + 32'h5A) & 32'hFFFFFF);
  endfunction

  function automatic logic [7:0] pat_x(int j, int seed);
    return 8'((j * 37 + seed * 11 + 3) & 32'hFF);
  endfunction

  function automatic int nbytes(int mode);
    return (mode == 3) ? 3 : (mode == 2) ? 2 : 1;
  endfunction

  function automatic logic [7:0] exp_byte(logic [23:0] w, int mode, int k);
    case (mode)
      0: return w[7:0];
      1: return w[15:8];
      2: return 8'(w >> (8 * k));
      default: return 8'(w >> (8 * (2 - k)));
    endcase
  endfunction

  task automatic run_xfer(input bit dir, input int mode, input int ws, input int nw,
                          input int ia0, input int ea0, input logic [7:0] page,
                          input int seed, input bit poke);
    logic [15:0] v;
    logic [15:0] ctrl;
    int nb;
    nb = nbytes(mode);
    @(negedge clk);
    for (int i = 0; i < 64; i++) imem[i] = pat_i(i, seed);
    for (int j = 0; j < 256; j++) xmem[j] = pat_x(j, seed);
    ctrl = {page, 5'b0, 2'(mode), dir};
    wr_reg(3'd4, 16'(ws));
    wr_reg(3'd0, 16'(ia0));
    wr_reg(3'd1, 16'(ea0));
    wr_reg(3'd2, ctrl);
    exp_ws = ws; exp_page = page; exp_dir_wr = dir;
    irq_cnt = 0; n_strobes = 0; bad_width = 0; bad_page = 0; bad_dir = 0; run_len = 0;
    wr_reg(3'd3, 16'(nw));
    chk("R1 busy after count write", 32'(busy), 1);
    if (poke) begin
      wr_reg(3'd0, 16'h0005);
      wr_reg(3'd1, 16'h0007);
      wr_reg(3'd2, 16'h0000);
      wr_reg(3'd3, 16'h0009);
    end
    for (int t = 0; t < 4000 && busy; t++) @(negedge clk);
    chk("R1 transfer finished", 32'(busy), 0);
    repeat (3) @(negedge clk);
    rd_reg(3'd3, v); chk("R3 count reads zero", 32'(v), 0);
    chk("R3 one irq pulse", 32'(irq_cnt), 1);
    rd_reg(3'd0, v); chk("R4 internal address advanced", 32'(v), 32'((ia0 + nw) & 32'h3FFF));
    rd_reg(3'd1, v); chk("R4 external address advanced", 32'(v), 32'((ea0 + nw * nb) & 32'h3FFF));
    chk("R4 page on bus", 32'(bad_page), 0);
    chk("R2 bytes per word", 32'(n_strobes), 32'(nw * nb));
    chk("R7 strobe width", 32'(bad_width), 0);
    chk("R6 strobe direction", 32'(bad_dir), 0);
    if (poke) begin
      rd_reg(3'd2, v); chk("R8 control kept", 32'(v), 32'(ctrl));
    end
    if (dir) begin
      for (int w = 0; w < nw; w++)
        for (int k = 0; k < nb; k++)
          chk("R5 written byte", 32'(xmem[(ea0 + w * nb + k) & 255]),
              32'(exp_byte(pat_i((ia0 + w) & 63, seed), mode, k)));
      chk("R5 byte past end untouched", 32'(xmem[(ea0 + nw * nb) & 255]),
          32'(pat_x((ea0 + nw * nb) & 255, seed)));
    end else begin
      for (int w = 0; w < nw; w++) begin
        logic [23:0] e;
        int b0;
        b0 = ea0 + w * nb;
        case (mode)
          0: e = {16'h0, pat_x(b0 & 255, seed)};
          1: e = {8'h0, pat_x(b0 & 255, seed), 8'h0};
          2: e = {8'h0, pat_x((b0 + 1) & 255, seed), pat_x(b0 & 255, seed)};
          default: e = {pat_x(b0 & 255, seed), pat_x((b0 + 1) & 255, seed),
                        pat_x((b0 + 2) & 255, seed)};
        endcase
        chk("R5 assembled word", 32'(imem[(ia0 + w) & 63]), 32'(e));
      end
      chk("R5 word past end untouched", 32'(imem[(ia0 + nw) & 63]),
          32'(pat_i((ia0 + nw) & 63, seed)));
    end
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy low", 32'(busy), 0);
    chk("R9 irq low", 32'(irq), 0);
    chk("R9 strobes low", 32'({ext_rd, ext_wr}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rd_reg(3'(s), v); chk("R9 register zero", 32'(v), 0);
    end
    rd_reg(3'd4, v); chk("R7 wait resets to 7", 32'(v), 7);

    // R1 zero count starts nothing
    irq_cnt = 0;
    wr_reg(3'd3, 16'h0000);
    repeat (5) begin
      @(negedge clk);
      chk("R1 zero count idle", 32'(busy), 0);
    end
    chk("R1 zero count no irq", 32'(irq_cnt), 0);

    // full sweep: direction x packing x wait
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 8; w++)
          run_xfer(d[0], m, w, 1 + ((w + m) % 4), m * 8 + w, d * 100 + w * 10 + m,
                   8'({d[0], 2'(m), 3'(w), 2'b10}), d * 32 + m * 8 + w, 1'b0);

    // R4 wrap of the 14-bit external address
    run_xfer(1'b1, 3, 1, 2, 3, 14'h3FFE, 8'hA5, 77, 1'b0);
    run_xfer(1'b0, 2, 0, 3, 9, 14'h3FFD, 8'h3C, 78, 1'b0);
    // R8 register writes during a transfer are ignored
    run_xfer(1'b1, 3, 7, 2, 20, 40, 8'h81, 90, 1'b1);
    run_xfer(1'b0, 1, 6, 3, 30, 60, 8'h42, 91, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule